// File: doc/BRIEF.md
# Iterative Integer Divider with Remainder

This block divides two integer operands over many cycles and returns either the quotient or the remainder. A single operation select chooses among eight variants: 32-bit or 64-bit operand width, signed or unsigned interpretation, and quotient or remainder output. All eight share one radix-2 shift-and-subtract engine. The engine works on operand magnitudes and applies the signs at the end. It produces one quotient bit per clock.

A caller pulses `start_i` for one cycle with the operation select and both operands present. The block raises `busy_o` while it iterates. It then pulses `done_o` for one cycle, with the result and two exception flags: division by zero and signed overflow. A zero divisor is detected at start. In that case the block answers in the very next cycle and does not iterate. Narrow operations read only the low half of each operand and return their result sign-extended to the full width.

Top module: `sdiv_unit`

## Requirements
- R1: Signed division truncates the quotient toward zero (for example -7 / 2 gives -3, and 5 / -3 gives -1).
- R2: The remainder equals dividend minus divisor times quotient, so a nonzero remainder carries the sign of the dividend and its magnitude is below that of the divisor (5 rem -3 gives 2, -7 rem 2 gives -1).
- R3: A zero divisor, in any of the eight variants, sets `div_zero_o` and clears `overflow_o`. The result is 0, `done_o` is high in the cycle right after the start cycle, and `busy_o` never rises.
- R4: A signed division of the most negative value by -1 sets `overflow_o`, at 32-bit and at 64-bit width. The quotient is returned as the most negative value of that width, and the remainder as 0.
- R5: With `op_signed_i` = 0 both operands are taken as unsigned, and `overflow_o` is never set.
- R6: With `op_wide_i` = 0 only bits 31:0 of each operand take part, and the 32-bit result is returned with bit 31 copied into bits 63:32. This also holds for unsigned operations.
- R7: For a nonzero divisor, `done_o` rises W+1 clock edges after the edge that samples `start_i`, where W is 64 when `op_wide_i` = 1 and 32 otherwise.
- R8: A `start_i` pulse while `busy_o` is high is ignored: the running operation completes with its own operands and its own timing.
- R9: `done_o` is a single-cycle pulse. `result_o`, `div_zero_o` and `overflow_o` hold their values until the next `done_o`.
- R10: After reset, `busy_o`, `done_o`, `result_o`, `div_zero_o` and `overflow_o` are all zero.
- R11: A `start_i` in the same cycle that `done_o` is high is accepted, and the new operation runs to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_wide_i | input | 1 | 1: 64-bit operands, 0: 32-bit operands |
| op_signed_i | input | 1 | 1: signed two's complement, 0: unsigned |
| op_rem_i | input | 1 | 1: return remainder, 0: return quotient |
| dividend_i | input | 64 | Dividend |
| divisor_i | input | 64 | Divisor |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Quotient or remainder, held until the next completion |
| div_zero_o | output | 1 | Divisor was zero |
| overflow_o | output | 1 | Signed most-negative by -1 |

## Verification
Two functions of this block can fall in the same cycle: the completion pulse of one operation and the acceptance of the next start. A second case is a start arriving while the engine is still counting. The bench provokes the first case by raising `start_i` in the very cycle it observes `done_o`. It then judges that the finished result is intact, that `busy_o` rises on the next cycle, and that the second result arrives with the full latency. It provokes the second case with a conflicting start in the middle of a long division. There it judges that both the result and the latency belong to the first request alone.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } dv_state_e;

  typedef struct packed {
    logic wide;
    logic sgn;
    logic rem;
  } dv_op_t;
endpackage

// File: rtl/sdiv_operand_prep.sv
module sdiv_operand_prep
  import sdiv_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  dv_op_t            op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] num_o,
  output logic [DATA_W-1:0] den_o,
  output logic              neg_quo_o,
  output logic              neg_rem_o,
  output logic              zero_div_o,
  output logic              ovf_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] WIDE_MIN   = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] NARROW_MIN = {{(HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};

  // Bring the operand to full width according to the selected variant.
  function automatic logic [DATA_W-1:0] widen(input logic [DATA_W-1:0] v,
                                              input logic wide, input logic sgn);
    if (wide) return v;
    return {{HALF_W{sgn & v[HALF_W-1]}}, v[HALF_W-1:0]};
  endfunction

  function automatic logic [DATA_W-1:0] magnitude(input logic [DATA_W-1:0] v,
                                                  input logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  logic [DATA_W-1:0] a_ext, b_ext, a_mag, b_mag;
  logic              a_neg, b_neg;

  assign a_ext = widen(a_i, op_i.wide, op_i.sgn);
  assign b_ext = widen(b_i, op_i.wide, op_i.sgn);
  assign a_neg = op_i.sgn & a_ext[DATA_W-1];
  assign b_neg = op_i.sgn & b_ext[DATA_W-1];
  assign a_mag = magnitude(a_ext, a_neg);
  assign b_mag = magnitude(b_ext, b_neg);

  // Narrow numerators sit in the upper half so only HALF_W steps are needed.
  assign num_o      = op_i.wide ? a_mag : {a_mag[HALF_W-1:0], {HALF_W{1'b0}}};
  assign den_o      = b_mag;
  assign neg_quo_o  = a_neg ^ b_neg;
  assign neg_rem_o  = a_neg;
  assign zero_div_o = (b_ext == '0);
  assign ovf_o      = op_i.sgn && (b_ext == '1) &&
                      (a_ext == (op_i.wide ? WIDE_MIN : NARROW_MIN));
endmodule

// File: rtl/sdiv_iter_core.sv
module sdiv_iter_core #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] num_i,
  input  logic [DATA_W-1:0] den_i,
  output logic [DATA_W-1:0] quo_o,
  output logic [DATA_W-1:0] rem_o,
  output logic              running_o,
  output logic              last_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] STEPS_WIDE   = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] STEPS_NARROW = CNT_W'(HALF_W);

  logic [DATA_W-1:0] part_r, quo_r, den_r;
  logic [CNT_W-1:0]  cnt_r;

  // One restoring step: shift in the next numerator bit, subtract if it fits.
  logic [DATA_W:0]   shifted;
  logic              step_take;
  logic [DATA_W:0]   step_diff;

  assign shifted   = {part_r, quo_r[DATA_W-1]};
  assign step_take = (shifted >= {1'b0, den_r});
  assign step_diff = shifted - {1'b0, den_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_r <= '0;
      quo_r  <= '0;
      den_r  <= '0;
      cnt_r  <= '0;
    end else if (load_i) begin
      part_r <= '0;
      quo_r  <= num_i;
      den_r  <= den_i;
      cnt_r  <= wide_i ? STEPS_WIDE : STEPS_NARROW;
    end else if (cnt_r != '0) begin
      part_r <= step_take ? step_diff[DATA_W-1:0] : shifted[DATA_W-1:0];
      quo_r  <= {quo_r[DATA_W-2:0], step_take};
      cnt_r  <= cnt_r - 1'b1;
    end
  end

  assign running_o = (cnt_r != '0);
  assign last_o    = (cnt_r == CNT_W'(1));
  assign quo_o     = quo_r;
  assign rem_o     = part_r;

  // R8
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !running_o);
  // R2
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (part_r < den_r));
endmodule

// File: rtl/sdiv_result_fix.sv
module sdiv_result_fix #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] quo_i,
  input  logic [DATA_W-1:0] rem_i,
  input  logic              neg_quo_i,
  input  logic              neg_rem_i,
  input  logic              wide_i,
  input  logic              sel_rem_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int HALF_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] apply_sign(input logic [DATA_W-1:0] v,
                                                   input logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [DATA_W-1:0] fit_width(input logic [DATA_W-1:0] v,
                                                  input logic wide);
    if (wide) return v;
    return {{HALF_W{v[HALF_W-1]}}, v[HALF_W-1:0]};
  endfunction

  logic [DATA_W-1:0] signed_val;
  assign signed_val = sel_rem_i ? apply_sign(rem_i, neg_rem_i)
                                : apply_sign(quo_i, neg_quo_i);
  assign res_o = fit_width(signed_val, wide_i);
endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit
  import sdiv_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_wide_i,
  input  logic              op_signed_i,
  input  logic              op_rem_i,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o,
  output logic              div_zero_o,
  output logic              overflow_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int LAT_W  = $clog2(DATA_W + 3);
  localparam logic [DATA_W-1:0] WIDE_MIN   = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] NARROW_MIN = {{(HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};

  dv_state_e         state_q;
  dv_op_t            op_in, op_q;
  logic              neg_quo_q, neg_rem_q, ovf_pend_q;
  logic              done_q, dz_q, ovf_q;
  logic [DATA_W-1:0] res_q;

  // Named internal events
  logic              accept;
  logic              accept_zero;
  logic              accept_run;
  logic [DATA_W-1:0] pre_num, pre_den;
  logic              pre_neg_quo, pre_neg_rem, pre_zero, pre_ovf;
  logic [DATA_W-1:0] core_quo, core_rem, fix_res;
  logic              core_running, core_last;

  assign op_in       = '{wide: op_wide_i, sgn: op_signed_i, rem: op_rem_i};
  assign accept      = (state_q == ST_IDLE) && start_i;
  assign accept_zero = accept && pre_zero;
  assign accept_run  = accept && !pre_zero;

  sdiv_operand_prep #(.DATA_W(DATA_W)) prep_i (
    .op_i       (op_in),
    .a_i        (dividend_i),
    .b_i        (divisor_i),
    .num_o      (pre_num),
    .den_o      (pre_den),
    .neg_quo_o  (pre_neg_quo),
    .neg_rem_o  (pre_neg_rem),
    .zero_div_o (pre_zero),
    .ovf_o      (pre_ovf)
  );

  sdiv_iter_core #(.DATA_W(DATA_W)) core_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (accept_run),
    .wide_i    (op_wide_i),
    .num_i     (pre_num),
    .den_i     (pre_den),
    .quo_o     (core_quo),
    .rem_o     (core_rem),
    .running_o (core_running),
    .last_o    (core_last)
  );

  sdiv_result_fix #(.DATA_W(DATA_W)) fix_i (
    .quo_i     (core_quo),
    .rem_i     (core_rem),
    .neg_quo_i (neg_quo_q),
    .neg_rem_i (neg_rem_q),
    .wide_i    (op_q.wide),
    .sel_rem_i (op_q.rem),
    .res_o     (fix_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      op_q       <= '0;
      neg_quo_q  <= 1'b0;
      neg_rem_q  <= 1'b0;
      ovf_pend_q <= 1'b0;
      done_q     <= 1'b0;
      dz_q       <= 1'b0;
      ovf_q      <= 1'b0;
      res_q      <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            op_q       <= op_in;
            neg_quo_q  <= pre_neg_quo;
            neg_rem_q  <= pre_neg_rem;
            ovf_pend_q <= pre_ovf;
            if (pre_zero) begin
              done_q <= 1'b1;
              res_q  <= '0;
              dz_q   <= 1'b1;
              ovf_q  <= 1'b0;
            end else begin
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (core_last) state_q <= ST_FIN;
        end
        ST_FIN: begin
          done_q  <= 1'b1;
          res_q   <= fix_res;
          dz_q    <= 1'b0;
          ovf_q   <= ovf_pend_q;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign result_o   = res_q;
  assign div_zero_o = dz_q;
  assign overflow_o = ovf_q;

  // Latency observer for the timing property
  logic [LAT_W-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lat_q <= '0;
    else if (accept_run) lat_q <= '0;
    else if (busy_o)     lat_q <= lat_q + 1'b1;
  end

  // R3
  zero_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_zero |=> (done_o && div_zero_o && !overflow_o && result_o == '0 && !busy_o));
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !op_q.sgn) |-> !overflow_o);
  // R6
  narrow_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !op_q.wide) |-> (result_o[DATA_W-1:HALF_W] == {HALF_W{result_o[HALF_W-1]}}));
  // R4
  ovf_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && overflow_o) |->
      (result_o == (op_q.rem ? '0 : (op_q.wide ? WIDE_MIN : NARROW_MIN))));
  // R2
  rem_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !div_zero_o && op_q.sgn && op_q.rem && result_o != '0)
      |-> (result_o[DATA_W-1] == neg_rem_q));
  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !div_zero_o) |-> (lat_q == LAT_W'((op_q.wide ? DATA_W : HALF_W) + 1)));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(result_o) && $stable(div_zero_o) && $stable(overflow_o)));
  // R9
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !div_zero_o) |=> !done_o || div_zero_o);
  // R11
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && accept_run) |=> (busy_o && core_running));
endmodule

// File: tb/sdiv_unit_tb.sv
`timescale 1ns/1ps
module sdiv_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        op_wide_i = 1'b0, op_signed_i = 1'b0, op_rem_i = 1'b0;
  logic [63:0] dividend_i = '0, divisor_i = '0;
  logic        busy_o, done_o, div_zero_o, overflow_o;
  logic [63:0] result_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #10 clk = ~clk;

  sdiv_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .op_wide_i(op_wide_i), .op_signed_i(op_signed_i), .op_rem_i(op_rem_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
    .div_zero_o(div_zero_o), .overflow_o(overflow_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected behaviour restated from the requirements.
  task automatic model(input bit w, input bit s, input bit r,
                       input logic [63:0] a, input logic [63:0] b,
                       output logic [63:0] res, output bit dz, output bit ov);
    dz = 0; ov = 0; res = '0;
    if (w) begin
      if (b == 0) begin dz = 1; return; end
      if (s) begin
        longint sa, sb;
        sa = a; sb = b;
        if (a == 64'h8000_0000_0000_0000 && b == '1) begin
          ov = 1; res = r ? 64'd0 : a;
        end else res = r ? 64'(sa % sb) : 64'(sa / sb);
      end else res = r ? a % b : a / b;
    end else begin
      logic [31:0] r32;
      if (b[31:0] == 0) begin dz = 1; return; end
      if (s) begin
        int sa, sb;
        sa = a[31:0]; sb = b[31:0];
        if (a[31:0] == 32'h8000_0000 && b[31:0] == 32'hFFFF_FFFF) begin
          ov = 1; r32 = r ? 32'd0 : 32'h8000_0000;
        end else r32 = r ? 32'(sa % sb) : 32'(sa / sb);
      end else r32 = r ? a[31:0] % b[31:0] : a[31:0] / b[31:0];
      res = {{32{r32[31]}}, r32};
    end
  endtask

  task automatic drive(input bit w, input bit s, input bit r,
                       input logic [63:0] a, input logic [63:0] b);
    op_wide_i = w; op_signed_i = s; op_rem_i = r;
    dividend_i = a; divisor_i = b; start_i = 1'b1;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done_o && lat < 200) begin @(negedge clk); lat++; end
  endtask

  task automatic judge(input bit w, input bit s, input bit r,
                       input logic [63:0] a, input logic [63:0] b,
                       input int lat, input string req);
    logic [63:0] er; bit edz, eov; int elat;
    model(w, s, r, a, b, er, edz, eov);
    elat = edz ? 1 : (w ? 66 : 34);
    chk(done_o === 1'b1, req, 64'(done_o), 64'd1);
    chk(result_o === er, req, result_o, er);
    chk(div_zero_o === edz, "R3", 64'(div_zero_o), 64'(edz));
    chk(overflow_o === eov, s ? "R4" : "R5", 64'(overflow_o), 64'(eov));
    chk(lat == elat, "R7", 64'(lat), 64'(elat));
  endtask

  task automatic run_op(input bit w, input bit s, input bit r,
                        input logic [63:0] a, input logic [63:0] b, input string req);
    int lat;
    @(negedge clk); drive(w, s, r, a, b);
    @(negedge clk); start_i = 1'b0;
    wait_done(lat);
    judge(w, s, r, a, b, lat, req);
  endtask

  task automatic t_reset();
    chk(busy_o === 1'b0, "R10", 64'(busy_o), 0);
    chk(done_o === 1'b0, "R10", 64'(done_o), 0);
    chk(result_o === 64'd0, "R10", result_o, 0);
    chk(div_zero_o === 1'b0 && overflow_o === 1'b0, "R10",
        64'({div_zero_o, overflow_o}), 0);
  endtask

  task automatic t_signed();
    run_op(1, 1, 0, 64'd5, -64'sd3, "R1");
    run_op(1, 1, 1, 64'd5, -64'sd3, "R2");
    run_op(1, 1, 0, -64'sd7, 64'd2, "R1");
    run_op(1, 1, 1, -64'sd7, 64'd2, "R2");
    run_op(0, 1, 0, 64'd5, 64'h0000_0000_FFFF_FFFD, "R1");
    run_op(0, 1, 1, 64'h0000_0000_FFFF_FFF9, 64'd2, "R2");
    run_op(1, 1, 1, -64'sd100, -64'sd7, "R2");
  endtask

  task automatic t_unsigned();
    run_op(1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, "R5");
    run_op(1, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd10, "R5");
    run_op(0, 0, 0, 64'h0000_0000_FFFF_FFF0, 64'd1, "R6");
    run_op(0, 0, 1, 64'h0000_0000_FFFF_FFF0, 64'd7, "R5");
    run_op(1, 0, 0, 64'h8000_0000_0000_0000, '1, "R5");
  endtask

  task automatic t_narrow_upper();
    run_op(0, 1, 0, 64'hDEAD_BEEF_0000_0064, 64'h1234_5678_FFFF_FFF6, "R6");
    run_op(0, 0, 1, 64'hFFFF_0000_0000_0065, 64'hAAAA_AAAA_0000_000A, "R6");
  endtask

  task automatic t_zero();
    for (int v = 0; v < 8; v++) begin
      bit busy_seen;
      @(negedge clk); drive(v[2], v[1], v[0], 64'h1234, v[2] ? 64'd0 : 64'hFFFF_FFFF_0000_0000);
      @(negedge clk); start_i = 1'b0;
      busy_seen = busy_o;
      judge(v[2], v[1], v[0], 64'h1234, v[2] ? 64'd0 : 64'hFFFF_FFFF_0000_0000, 1, "R3");
      chk(!busy_seen, "R3", 64'(busy_seen), 0);
    end
  endtask

  task automatic t_overflow();
    run_op(1, 1, 0, 64'h8000_0000_0000_0000, '1, "R4");
    run_op(1, 1, 1, 64'h8000_0000_0000_0000, '1, "R4");
    run_op(0, 1, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R4");
    run_op(0, 1, 1, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R4");
    run_op(0, 0, 0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, "R5");
  endtask

  task automatic t_busy_ignore();
    int lat;
    @(negedge clk); drive(1, 1, 0, 64'd1_000_000_007, -64'sd13);
    @(negedge clk); start_i = 1'b0; lat = 1;
    repeat (5) begin @(negedge clk); lat++; end
    drive(0, 0, 1, 64'd77, 64'd0);
    @(negedge clk); lat++; start_i = 1'b0;
    chk(busy_o === 1'b1 && done_o === 1'b0, "R8", 64'({busy_o, done_o}), 64'b10);
    while (!done_o && lat < 200) begin @(negedge clk); lat++; end
    judge(1, 1, 0, 64'd1_000_000_007, -64'sd13, lat, "R8");
  endtask

  task automatic t_hold();
    logic [63:0] held;
    run_op(1, 1, 0, -64'sd999, 64'd10, "R1");
    held = result_o;
    @(negedge clk);
    chk(done_o === 1'b0, "R9", 64'(done_o), 0);
    repeat (4) @(negedge clk);
    chk(result_o === held, "R9", result_o, held);
    chk(div_zero_o === 1'b0 && overflow_o === 1'b0, "R9",
        64'({div_zero_o, overflow_o}), 0);
  endtask

  task automatic t_back_to_back();
    int lat;
    @(negedge clk); drive(0, 1, 0, 64'h0000_0000_FFFF_FF00, 64'd16);
    @(negedge clk); start_i = 1'b0;
    wait_done(lat);
    judge(0, 1, 0, 64'h0000_0000_FFFF_FF00, 64'd16, lat, "R11");
    drive(1, 0, 1, 64'd123_456_789, 64'd1000);
    @(negedge clk); start_i = 1'b0;
    chk(busy_o === 1'b1, "R11", 64'(busy_o), 1);
    chk(result_o === 64'hFFFF_FFFF_FFFF_FFF0, "R11", result_o, 64'hFFFF_FFFF_FFFF_FFF0);
    wait_done(lat);
    judge(1, 0, 1, 64'd123_456_789, 64'd1000, lat, "R11");
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 24; i++) begin
      logic [63:0] a, b;
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 7; lfsr ^= lfsr << 17;
      a = lfsr;
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 7; lfsr ^= lfsr << 17;
      b = lfsr >> lfsr[5:0];
      run_op(i[0], i[1], i[2], a, b, i[2] ? "R2" : "R1");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_signed();
    t_unsigned();
    t_narrow_upper();
    t_zero();
    t_overflow();
    t_busy_ignore();
    t_hold();
    t_back_to_back();
    t_sweep();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule